// File: doc/BRIEF.md
# DRAM Controller Operating State Sequencer

This block steers a DRAM protocol controller into one of two operating states, "config" or "access", on request. It reads the controller's status word, writes state commands to the controller's control register through a one-cycle write strobe, and polls the status after every command until the controller has settled into the state that step was meant to reach. Depending on where the controller starts, one request produces zero to three commands: wake it from low power, move it to config, and release it to access.

A request is a one-bit target (0 = config, 1 = access) offered with `req_valid`. It is taken only when `req_ready` is high, and `req_ready` is high only while the sequencer is idle. An offer made while the sequencer is busy is neither taken nor queued, so the requester must keep `req_valid` high until it sees `req_ready`. When the sequence ends, `done` pulses for one cycle. The status word carries the controller state in bits [2:0] and a low-power trigger field in bits [6:4]. Bit 3 is not used. When the controller sits in low power because of trigger code 1, an access request leaves it there.

The controller is outside this block. Its status is treated as a free-running input that may pass through request (transient) states at any time.

Top module: `osm_mgr`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `ctl_cmd_wr` are 0.
- R2: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance up to and including the `done` cycle. An offer during that time has no effect on the commands written or on the number of `done` pulses.
- R3: Target config from low power (state code 5): the block writes wakeup (command 4), waits for access (state 3), writes config (command 1), waits for config (state 1), then finishes.
- R4: Target config from access (3) or init-mem (0): the block writes config (1), waits for state 1, then finishes.
- R5: When the controller is already in the target state (config 1 for target 0, access 3 for target 1), the block writes no command. `done` rises in the second cycle after the accepting clock edge.
- R6: Target access: the block first reaches config as in R3/R4 (no step when already in config). It then writes go (command 2), waits until the state field is no longer 1, and finishes.
- R7: Target access with state 5 and trigger field (status bits [6:4]) equal to 1: the block writes no command and finishes.
- R8: While the state field shows a request state (2, 4, 6 or 7) at evaluation time, the block waits. It decides its first step once a stable state (0, 1, 3, 5) appears.
- R9: `done` is a one-cycle pulse, given exactly once per accepted request. `ctl_cmd_wr` is a one-cycle pulse per command, and it never coincides with `done`.
- R10: Command codes are init 0, config 1, go 2, sleep 3, wakeup 4. Only 1, 2 and 4 are ever written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request taken this cycle if valid |
| req_target | input | 1 | Target state: 0 = config, 1 = access |
| ctl_status | input | 7 | Controller status: [2:0] state, [6:4] low-power trigger |
| ctl_cmd | output | 3 | State command for the controller control register |
| ctl_cmd_wr | output | 1 | One-cycle write strobe for `ctl_cmd` |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can meet in one cycle: the `done` pulse of one request and the offer of the next. The bench holds `req_valid` high across the end of a config-to-access walk. It judges that `req_ready` is low in the `done` cycle, that the held request is then taken exactly once, and that this second request, which finds the controller still settling from go, waits for access and finishes with no command. Across the run, randomised controller latencies and request states test the waits, and the command trail is compared with the sequence the bench predicts from the start state.

// File: rtl/osm_pkg.sv
package osm_pkg;
  localparam int ST_W  = 3;
  localparam int CMD_W = 3;

  typedef enum logic [ST_W-1:0] {
    CS_INIT_MEM = 3'd0,
    CS_CONFIG   = 3'd1,
    CS_CFG_REQ  = 3'd2,
    CS_ACCESS   = 3'd3,
    CS_ACC_REQ  = 3'd4,
    CS_LOWPWR   = 3'd5,
    CS_LP_ENTRY = 3'd6,
    CS_LP_EXIT  = 3'd7
  } ctl_state_e;

  typedef enum logic [CMD_W-1:0] {
    CC_INIT   = 3'd0,
    CC_CONFIG = 3'd1,
    CC_GO     = 3'd2,
    CC_SLEEP  = 3'd3,
    CC_WAKE   = 3'd4
  } ctl_cmd_e;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_WAKE,
    STEP_CFG,
    STEP_GO
  } step_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_EVAL,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_FIN
  } seq_e;
endpackage

// File: rtl/osm_stat_decode.sv
module osm_stat_decode
  import osm_pkg::*;
#(
  parameter int TRIG_LSB  = 4,
  parameter int TRIG_W    = 3,
  parameter int SKIP_TRIG = 1,
  localparam int STAT_W   = TRIG_LSB + TRIG_W
) (
  input  logic [STAT_W-1:0] status,
  output ctl_state_e        st,
  output logic              stable,
  output logic              trig_hit
);
  assign st       = ctl_state_e'(status[ST_W-1:0]);
  assign trig_hit = (status[STAT_W-1:TRIG_LSB] == TRIG_W'(SKIP_TRIG));

  always_comb begin
    case (st)
      CS_INIT_MEM, CS_CONFIG, CS_ACCESS, CS_LOWPWR: stable = 1'b1;
      default:                                      stable = 1'b0;
    endcase
  end

  generate
    if (TRIG_LSB > ST_W) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^status[TRIG_LSB-1:ST_W];
    end
  endgenerate
endmodule

// File: rtl/osm_step_plan.sv
module osm_step_plan
  import osm_pkg::*;
(
  input  ctl_state_e st,
  input  logic       tgt_access,
  input  logic       trig_hit,
  input  step_e      cur_step,
  output step_e      first_step,
  output step_e      next_step,
  output logic       step_met,
  output ctl_cmd_e   step_cmd
);
  always_comb begin
    case (st)
      CS_LOWPWR:   first_step = (tgt_access && trig_hit) ? STEP_NONE : STEP_WAKE;
      CS_ACCESS:   first_step = tgt_access ? STEP_NONE : STEP_CFG;
      CS_INIT_MEM: first_step = STEP_CFG;
      CS_CONFIG:   first_step = tgt_access ? STEP_GO : STEP_NONE;
      default:     first_step = STEP_NONE;
    endcase
  end

  always_comb begin
    next_step = STEP_NONE;
    step_met  = 1'b0;
    step_cmd  = CC_INIT;
    case (cur_step)
      STEP_WAKE: begin
        next_step = STEP_CFG;
        step_met  = (st == CS_ACCESS);
        step_cmd  = CC_WAKE;
      end
      STEP_CFG: begin
        next_step = tgt_access ? STEP_GO : STEP_NONE;
        step_met  = (st == CS_CONFIG);
        step_cmd  = CC_CONFIG;
      end
      STEP_GO: begin
        next_step = STEP_NONE;
        step_met  = (st != CS_CONFIG);
        step_cmd  = CC_GO;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/osm_seq.sv
module osm_seq
  import osm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_target,
  input  logic  stable,
  input  step_e first_step,
  input  step_e next_step,
  input  logic  step_met,
  output step_e cur_step,
  output logic  tgt_access,
  output logic  idle,
  output logic  issue,
  output logic  fin
);
  seq_e fsm, fsm_nxt;

  always_comb begin
    fsm_nxt = fsm;
    case (fsm)
      SQ_IDLE:  if (req_valid) fsm_nxt = SQ_EVAL;
      SQ_EVAL:  if (stable) fsm_nxt = (first_step == STEP_NONE) ? SQ_FIN : SQ_ISSUE;
      SQ_ISSUE: fsm_nxt = SQ_WAIT;
      SQ_WAIT:  if (step_met) fsm_nxt = (next_step == STEP_NONE) ? SQ_FIN : SQ_ISSUE;
      SQ_FIN:   fsm_nxt = SQ_IDLE;
      default:  fsm_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm        <= SQ_IDLE;
      cur_step   <= STEP_NONE;
      tgt_access <= 1'b0;
    end else begin
      fsm <= fsm_nxt;
      if (fsm == SQ_IDLE && req_valid) tgt_access <= req_target;
      if (fsm == SQ_EVAL && stable) cur_step <= first_step;
      if (fsm == SQ_WAIT && step_met) cur_step <= next_step;
    end
  end

  assign idle  = (fsm == SQ_IDLE);
  assign issue = (fsm == SQ_ISSUE);
  assign fin   = (fsm == SQ_FIN);
endmodule

// File: rtl/osm_mgr.sv
module osm_mgr
  import osm_pkg::*;
#(
  parameter int TRIG_LSB  = 4,
  parameter int TRIG_W    = 3,
  parameter int SKIP_TRIG = 1,
  localparam int STAT_W   = TRIG_LSB + TRIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_target,
  input  logic [STAT_W-1:0] ctl_status,
  output logic [CMD_W-1:0]  ctl_cmd,
  output logic              ctl_cmd_wr,
  output logic              done
);
  ctl_state_e st;
  logic       stable, trig_hit, tgt_access, step_met;
  step_e      first_step, next_step, cur_step;
  ctl_cmd_e   step_cmd;

  osm_stat_decode #(
    .TRIG_LSB (TRIG_LSB),
    .TRIG_W   (TRIG_W),
    .SKIP_TRIG(SKIP_TRIG)
  ) u_dec (
    .status  (ctl_status),
    .st      (st),
    .stable  (stable),
    .trig_hit(trig_hit)
  );

  osm_step_plan u_plan (
    .st        (st),
    .tgt_access(tgt_access),
    .trig_hit  (trig_hit),
    .cur_step  (cur_step),
    .first_step(first_step),
    .next_step (next_step),
    .step_met  (step_met),
    .step_cmd  (step_cmd)
  );

  osm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_target(req_target),
    .stable    (stable),
    .first_step(first_step),
    .next_step (next_step),
    .step_met  (step_met),
    .cur_step  (cur_step),
    .tgt_access(tgt_access),
    .idle      (req_ready),
    .issue     (ctl_cmd_wr),
    .fin       (done)
  );

  assign ctl_cmd = step_cmd;
endmodule

// File: rtl/osm_chk.sv
module osm_chk
  import osm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CMD_W-1:0] ctl_cmd,
  input logic             ctl_cmd_wr,
  input logic             done
);
  // R10
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd_wr |-> (ctl_cmd == 3'd1 || ctl_cmd == 3'd2 || ctl_cmd == 3'd4));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd_wr |=> !ctl_cmd_wr);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctl_cmd_wr);
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  // R6
  go_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cmd_wr && ctl_cmd == 3'd2) |=> !done);
endmodule

bind osm_mgr osm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ctl_cmd   (ctl_cmd),
  .ctl_cmd_wr(ctl_cmd_wr),
  .done      (done)
);

// File: tb/sim_osm_mgr.sv
module sim_osm_mgr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_target = 1'b0;
  logic       req_ready, ctl_cmd_wr, done;
  logic [2:0] ctl_cmd;
  logic [6:0] ctl_status;

  int checks = 0;
  int errors = 0;

  // controller model
  int  st = 0, trg = 0, lat_max = 0, pcnt = 0, pcode = 0, pfin = 0;
  bit  pend = 1'b0;
  logic [11:0] rec = '0;
  int  rec_n = 0;
  int  done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osm_mgr u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .ctl_status(ctl_status), .ctl_cmd(ctl_cmd),
    .ctl_cmd_wr(ctl_cmd_wr), .done(done)
  );

  always_comb begin
    logic [2:0] shown;
    shown = pend ? 3'(pcode) : 3'(st);
    ctl_status = {3'(trg), 1'b0, shown};
  end

  always @(negedge clk) begin
    if (done) done_cnt = done_cnt + 1;
    if (ctl_cmd_wr) begin
      rec   = {rec[8:0], ctl_cmd};
      rec_n = rec_n + 1;
      pend  = 1'b1;
      pcnt  = lat_max;
      case (ctl_cmd)
        3'd1:    begin pcode = 2; pfin = 1; end
        3'd2:    begin pcode = 4; pfin = 3; end
        default: begin pcode = 7; pfin = 3; end
      endcase
    end else if (pend) begin
      if (pcnt == 0) begin pend = 1'b0; st = pfin; end
      else pcnt = pcnt - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void expect_seq(input int s, input int t, input int tr,
                                     output logic [11:0] seq, output int n, output int fin);
    seq = '0; n = 0; fin = s;
    if (s == 5 && t == 1 && tr == 1) return;
    if (s == 5) begin seq = {seq[8:0], 3'd4}; n++; end
    if (s == 5 || s == 0 || (s == 3 && t == 0)) begin seq = {seq[8:0], 3'd1}; n++; end
    if (t == 1 && s != 3) begin seq = {seq[8:0], 3'd2}; n++; end
    if (n != 0) fin = (t == 1) ? 3 : 1;
  endfunction

  function automatic string tag_of(input int s, input int t, input int tr, input int pre, input int n);
    if (pre > 0) return "R8";
    if (s == 5 && t == 1 && tr == 1) return "R7";
    if (n == 0) return "R5";
    if (s == 5 && t == 0) return "R3";
    if (t == 1) return "R6";
    return "R4";
  endfunction

  task automatic run(input int s, input int t, input int tr, input int pre, input int lat);
    logic [11:0] eseq;
    int en, efin, d0, guard;
    string tag;
    expect_seq(s, t, tr, eseq, en, efin);
    tag = tag_of(s, t, tr, pre, en);
    @(negedge clk);
    st = s; trg = tr; lat_max = lat;
    if (pre > 0) begin pend = 1'b1; pcnt = pre; pcode = 6; pfin = s; end
    rec = '0; rec_n = 0; d0 = done_cnt;
    req_valid = 1'b1; req_target = t[0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    if (pre == 0 && en == 0) check(done == 1'b1, "R5", int'(done), 1);
    guard = 0;
    while (done_cnt == d0 && guard < 300) begin @(negedge clk); guard++; end
    repeat (lat + 4) @(negedge clk);
    check(rec == eseq && rec_n == en, tag, int'(rec), int'(eseq));
    check(done_cnt == d0 + 1, "R9", done_cnt - d0, 1);
    check(st == efin, tag, st, efin);
  endtask

  initial begin
    int d0, guard;
    bit seen_first;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", int'(req_ready), 1);
    check(done == 1'b0, "R1", int'(done), 0);
    check(ctl_cmd_wr == 1'b0, "R1", int'(ctl_cmd_wr), 0);
    rst_n = 1'b1;

    // directed corners
    run(5, 0, 0, 0, 2);   // R3
    run(3, 0, 0, 0, 1);   // R4
    run(0, 0, 0, 0, 0);   // R4
    run(1, 0, 0, 0, 0);   // R5
    run(3, 1, 0, 0, 0);   // R5
    run(0, 1, 0, 0, 3);   // R6
    run(5, 1, 2, 0, 1);   // R6
    run(5, 1, 1, 0, 1);   // R7
    run(5, 0, 1, 0, 1);   // R3 trigger 1 does not block config target
    run(3, 0, 0, 4, 1);   // R8
    run(1, 1, 0, 3, 2);   // R8
    check(rec == 12'o2, "R10", int'(rec), 2);

    // R2: offer while busy is ignored
    @(negedge clk);
    st = 5; trg = 0; lat_max = 3; rec = '0; rec_n = 0; d0 = done_cnt;
    req_valid = 1'b1; req_target = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_target = 1'b1;
    check(req_ready == 1'b0, "R2", int'(req_ready), 0);
    @(negedge clk); req_valid = 1'b0;
    guard = 0;
    while (done_cnt == d0 && guard < 300) begin @(negedge clk); guard++; end
    repeat (8) @(negedge clk);
    check(rec == 12'o41 && rec_n == 2, "R2", int'(rec), 'o41);
    check(done_cnt == d0 + 1, "R2", done_cnt - d0, 1);

    // R2 with R9: next request held across the done cycle
    @(negedge clk);
    st = 1; trg = 0; lat_max = 2; rec = '0; rec_n = 0; d0 = done_cnt;
    req_valid = 1'b1; req_target = 1'b1;
    seen_first = 1'b0; guard = 0;
    while (done_cnt < d0 + 2 && guard < 300) begin
      @(negedge clk); guard++;
      if (done && !seen_first) begin
        seen_first = 1'b1;
        check(req_ready == 1'b0, "R2", int'(req_ready), 0);
      end
    end
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(done_cnt == d0 + 2, "R9", done_cnt - d0, 2);
    check(rec == 12'o2 && rec_n == 1, "R6", int'(rec), 2);
    check(st == 3, "R6", st, 3);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      int s, t, tr, pre, lat;
      case ($urandom_range(3, 0))
        0: s = 0;
        1: s = 1;
        2: s = 3;
        default: s = 5;
      endcase
      t   = int'($urandom_range(1, 0));
      tr  = int'($urandom_range(2, 0));
      pre = ($urandom_range(3, 0) == 0) ? int'($urandom_range(4, 1)) : 0;
      lat = int'($urandom_range(3, 0));
      run(s, t, tr, pre, lat);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule